// File: doc/BRIEF.md
# Audio Sample Word Formatter

This block sits between 32-bit sample FIFOs and a biphase subframe framer. On the transmit side it takes FIFO words through a valid/ready stream and turns each into one or two subframes. Each subframe carries a left/right tag, a 24-bit audio field, the validity, user, channel-status and parity bits, and a 4-bit preamble code. On the receive side it takes subframes from the deframer and assembles FIFO words in the same layouts. Both directions are pure combinational paths with a little sequencing state, so the block adds no latency and never stores more than half a word.

A 2-bit mode field selects 16-, 20-, 24-bit or raw operation. A pack bit, honoured only in 16-bit mode, puts two channels in one FIFO word. The configuration is expected to change only while reset is held.

Top module: `sample_word_fmt`

## Requirements
- R1: Mode code 0 is 16-bit, 1 is 20-bit and 2 is 24-bit. In these unpacked modes each transmit word yields exactly one subframe. The sample is taken from bit 0 of the word and left-justified into the 24-bit audio field with zero low bits: audio = {word[15:0],8'h00}, {word[19:0],4'h0} or word[23:0]. The V, U and C bits and the preamble code are driven to 0.
- R2: Mode code 3 (raw) maps word bit 31 to P, bit 30 to C, bit 29 to U and bit 28 to V. It maps word[27:4] to the audio field (20 data bits above 4 aux bits) and word[3:0] to the preamble code. P is passed through unchanged.
- R3: In every mode except raw, the block generates P so that the audio field, V, U, C and P together hold an even number of ones.
- R4: Packed mode is mode 0 with the pack bit set. It emits word[15:0] first and word[31:16] second, each left-justified as in R1. The FIFO word is popped (txWordReady high) only on the handshake of the second subframe.
- R5: The pack bit has no effect in modes 1, 2 and 3.
- R6: The transmit left/right tag is 1 (left) after reset and inverts after every subframe handshake (txWordValid and txSubReady both high).
- R7: txSubValid follows txWordValid. In unpacked modes txWordReady follows txSubReady. On the receive side, in unpacked modes rxWordValid follows rxSubValid and rxSubReady follows rxWordReady.
- R8: Receive in modes 0 to 2 gives word = {P,C,U,V, preamble[3:0], sample right-aligned at bit 0}. The sample is audio[23:8], audio[23:4] or audio[23:0], and the bits between the sample and bit 24 are zero.
- R9: Receive in raw mode gives word = {P,C,U,V, audio[23:0], preamble[3:0]}.
- R10: Packed receive always accepts a left subframe and holds audio[23:8], replacing any half already held. A right subframe that arrives with a half held produces word = {right audio[23:8], held half} and frees the hold on its handshake. A right subframe that arrives with nothing held is accepted and dropped without producing a word.
- R11: After reset the transmit tag is left and no receive half is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgMode | input | 2 | Sample format code (0 16-bit, 1 20-bit, 2 24-bit, 3 raw) |
| cfgPack | input | 1 | Two channels per word, honoured in 16-bit mode only |
| txWordValid | input | 1 | Transmit FIFO word available |
| txWordReady | output | 1 | Transmit FIFO word consumed |
| txWord | input | 32 | Transmit FIFO word |
| txSubValid | output | 1 | Subframe available to the framer |
| txSubReady | input | 1 | Framer takes the subframe |
| txSubLeft | output | 1 | Subframe is the left channel |
| txSubAudio | output | 24 | Subframe audio field |
| txSubP | output | 1 | Parity bit |
| txSubC | output | 1 | Channel-status bit |
| txSubU | output | 1 | User bit |
| txSubV | output | 1 | Validity bit |
| txSubPre | output | 4 | Preamble code |
| rxSubValid | input | 1 | Received subframe available |
| rxSubReady | output | 1 | Received subframe consumed |
| rxSubLeft | input | 1 | Received subframe is the left channel |
| rxSubAudio | input | 24 | Received audio field |
| rxSubP | input | 1 | Received parity bit |
| rxSubC | input | 1 | Received channel-status bit |
| rxSubU | input | 1 | Received user bit |
| rxSubV | input | 1 | Received validity bit |
| rxSubPre | input | 4 | Received preamble code |
| rxWordValid | output | 1 | Receive FIFO word available |
| rxWordReady | input | 1 | Receive FIFO takes the word |
| rxWord | output | 32 | Receive FIFO word |

## Verification
The bench runs every mode with and without the pack bit. In each run it drives pseudo-random word data, valid/ready patterns and left/right tags. Random stalls on txSubReady show whether the packed half-select and the tag advance only on a real handshake. Random tags on the receive side reach the packed corner cases: a left overwriting a held half, and an orphan right being dropped. The mode sweep with the pack bit set in modes 1 to 3 shows whether packing wrongly leaks outside 16-bit mode. Dense random data bits test each field position and the parity on every cycle.

// File: rtl/swf_pkg.sv
`timescale 1ns/1ps
package swf_pkg;
  localparam int WORD_W  = 32;
  localparam int AUDIO_W = 24;
  localparam int HALF_W  = 16;
  localparam int NIB_W   = 4;
  localparam int PAD16   = AUDIO_W - HALF_W;
  localparam int PAD20   = AUDIO_W - 20;

  typedef enum logic [1:0] {
    MODE_S16 = 2'd0,
    MODE_S20 = 2'd1,
    MODE_S24 = 2'd2,
    MODE_RAW = 2'd3
  } fmt_mode_e;

  typedef struct packed {
    logic packEn;
    logic txHigh;
    logic rxLoad;
  } fmt_strobe_t;
endpackage

// File: rtl/swf_ctrl.sv
`timescale 1ns/1ps
module swf_ctrl
  import swf_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  fmt_mode_e   mode,
  input  logic        cfgPack,
  input  logic        txWordValid,
  output logic        txWordReady,
  output logic        txSubValid,
  input  logic        txSubReady,
  output logic        txSubLeft,
  input  logic        rxSubValid,
  output logic        rxSubReady,
  input  logic        rxSubLeft,
  output logic        rxWordValid,
  input  logic        rxWordReady,
  output fmt_strobe_t strb
);
  logic packEn;
  logic txPhase;
  logic txLeftQ;
  logic txFire;
  logic rxHeld;
  logic rxPairSlot;
  logic rxCapture;

  assign packEn = cfgPack && (mode == MODE_S16);

  // transmit sequencing
  assign txSubValid  = txWordValid;
  assign txFire      = txWordValid && txSubReady;
  assign txWordReady = packEn ? (txPhase && txSubReady) : txSubReady;
  assign txSubLeft   = txLeftQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txPhase <= 1'b0;
      txLeftQ <= 1'b1;
    end else begin
      if (txFire) txLeftQ <= ~txLeftQ;
      if (!packEn)     txPhase <= 1'b0;
      else if (txFire) txPhase <= ~txPhase;
    end
  end

  // receive pairing
  assign rxPairSlot  = packEn && !rxSubLeft && rxHeld;
  assign rxCapture   = packEn && rxSubValid && rxSubLeft;
  assign rxWordValid = packEn ? (rxSubValid && rxPairSlot) : rxSubValid;
  assign rxSubReady  = packEn ? (rxPairSlot ? rxWordReady : 1'b1) : rxWordReady;

  always_ff @(posedge clk) begin
    if (!rstN)                                      rxHeld <= 1'b0;
    else if (!packEn)                               rxHeld <= 1'b0;
    else if (rxCapture)                             rxHeld <= 1'b1;
    else if (rxSubValid && !rxSubLeft && rxSubReady) rxHeld <= 1'b0;
  end

  assign strb.packEn = packEn;
  assign strb.txHigh = txPhase;
  assign strb.rxLoad = rxCapture;

  AST_PACK_POP_ON_RIGHT: assert property (@(posedge clk) disable iff (!rstN)
    (packEn && txWordValid && txWordReady) |-> !txSubLeft);            // R4
  AST_TAG_TOGGLE: assert property (@(posedge clk) disable iff (!rstN)
    (txWordValid && txSubReady) |=> (txSubLeft != $past(txSubLeft)));  // R6
  AST_TX_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !txSubReady |-> !txWordReady);                                     // R7
  AST_RX_NO_EARLY_WORD: assert property (@(posedge clk) disable iff (!rstN)
    (packEn && rxWordValid) |-> !rxSubLeft);                           // R10
endmodule

// File: rtl/swf_datapath.sv
`timescale 1ns/1ps
module swf_datapath
  import swf_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  fmt_mode_e           mode,
  input  fmt_strobe_t         strb,
  input  logic [WORD_W-1:0]   txWord,
  output logic [AUDIO_W-1:0]  txSubAudio,
  output logic                txSubP,
  output logic                txSubC,
  output logic                txSubU,
  output logic                txSubV,
  output logic [NIB_W-1:0]    txSubPre,
  input  logic [AUDIO_W-1:0]  rxSubAudio,
  input  logic                rxSubP,
  input  logic                rxSubC,
  input  logic                rxSubU,
  input  logic                rxSubV,
  input  logic [NIB_W-1:0]    rxSubPre,
  output logic [WORD_W-1:0]   rxWord
);
  logic [HALF_W-1:0]  txPick;
  logic [HALF_W-1:0]  heldLeft;
  logic [NIB_W-1:0]   rxStatus;
  logic               genParity;

  // transmit field extraction
  assign txPick = strb.txHigh ? txWord[WORD_W-1:HALF_W] : txWord[HALF_W-1:0];

  always_comb begin
    txSubC   = 1'b0;
    txSubU   = 1'b0;
    txSubV   = 1'b0;
    txSubPre = '0;
    if (strb.packEn) begin
      txSubAudio = {txPick, {PAD16{1'b0}}};
    end else begin
      unique case (mode)
        MODE_S16: txSubAudio = {txWord[HALF_W-1:0], {PAD16{1'b0}}};
        MODE_S20: txSubAudio = {txWord[19:0], {PAD20{1'b0}}};
        MODE_S24: txSubAudio = txWord[AUDIO_W-1:0];
        default: begin
          txSubAudio = txWord[27:4];
          txSubC     = txWord[30];
          txSubU     = txWord[29];
          txSubV     = txWord[28];
          txSubPre   = txWord[3:0];
        end
      endcase
    end
  end

  assign genParity = ^{txSubAudio, txSubC, txSubU, txSubV};
  assign txSubP    = (mode == MODE_RAW) ? txWord[31] : genParity;

  // receive assembly
  always_ff @(posedge clk) begin
    if (!rstN)            heldLeft <= '0;
    else if (strb.rxLoad) heldLeft <= rxSubAudio[AUDIO_W-1:PAD16];
  end

  assign rxStatus = {rxSubP, rxSubC, rxSubU, rxSubV};

  always_comb begin
    if (strb.packEn) begin
      rxWord = {rxSubAudio[AUDIO_W-1:PAD16], heldLeft};
    end else begin
      unique case (mode)
        MODE_S16: rxWord = {rxStatus, rxSubPre, {PAD16{1'b0}}, rxSubAudio[AUDIO_W-1:PAD16]};
        MODE_S20: rxWord = {rxStatus, rxSubPre, {PAD20{1'b0}}, rxSubAudio[AUDIO_W-1:PAD20]};
        MODE_S24: rxWord = {rxStatus, rxSubPre, rxSubAudio};
        default:  rxWord = {rxStatus, rxSubAudio, rxSubPre};
      endcase
    end
  end

  AST_RAW_P_PASS: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_RAW) |-> (txSubP == txWord[31]));                              // R2
  AST_PARITY_EVEN: assert property (@(posedge clk) disable iff (!rstN)
    (mode != MODE_RAW) |-> ((^{txSubAudio, txSubP, txSubC, txSubU, txSubV}) == 1'b0)); // R3
  AST_LOW_PAD_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_S16) |-> (txSubAudio[PAD16-1:0] == '0));                       // R1
endmodule

// File: rtl/sample_word_fmt.sv
`timescale 1ns/1ps
module sample_word_fmt
  import swf_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  cfgMode,
  input  logic        cfgPack,
  input  logic        txWordValid,
  output logic        txWordReady,
  input  logic [31:0] txWord,
  output logic        txSubValid,
  input  logic        txSubReady,
  output logic        txSubLeft,
  output logic [23:0] txSubAudio,
  output logic        txSubP,
  output logic        txSubC,
  output logic        txSubU,
  output logic        txSubV,
  output logic [3:0]  txSubPre,
  input  logic        rxSubValid,
  output logic        rxSubReady,
  input  logic        rxSubLeft,
  input  logic [23:0] rxSubAudio,
  input  logic        rxSubP,
  input  logic        rxSubC,
  input  logic        rxSubU,
  input  logic        rxSubV,
  input  logic [3:0]  rxSubPre,
  output logic        rxWordValid,
  input  logic        rxWordReady,
  output logic [31:0] rxWord
);
  fmt_mode_e   mode;
  fmt_strobe_t strb;

  assign mode = fmt_mode_e'(cfgMode);

  swf_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .mode       (mode),
    .cfgPack    (cfgPack),
    .txWordValid(txWordValid),
    .txWordReady(txWordReady),
    .txSubValid (txSubValid),
    .txSubReady (txSubReady),
    .txSubLeft  (txSubLeft),
    .rxSubValid (rxSubValid),
    .rxSubReady (rxSubReady),
    .rxSubLeft  (rxSubLeft),
    .rxWordValid(rxWordValid),
    .rxWordReady(rxWordReady),
    .strb       (strb)
  );

  swf_datapath u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .mode      (mode),
    .strb      (strb),
    .txWord    (txWord),
    .txSubAudio(txSubAudio),
    .txSubP    (txSubP),
    .txSubC    (txSubC),
    .txSubU    (txSubU),
    .txSubV    (txSubV),
    .txSubPre  (txSubPre),
    .rxSubAudio(rxSubAudio),
    .rxSubP    (rxSubP),
    .rxSubC    (rxSubC),
    .rxSubU    (rxSubU),
    .rxSubV    (rxSubV),
    .rxSubPre  (rxSubPre),
    .rxWord    (rxWord)
  );
endmodule

// File: tb/sample_word_fmt_bench.sv
`timescale 1ns/1ps
module sample_word_fmt_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  cfgMode = 2'd0;
  logic        cfgPack = 1'b0;
  logic        txWordValid = 1'b0;
  logic        txWordReady;
  logic [31:0] txWord = '0;
  logic        txSubValid;
  logic        txSubReady = 1'b0;
  logic        txSubLeft;
  logic [23:0] txSubAudio;
  logic        txSubP, txSubC, txSubU, txSubV;
  logic [3:0]  txSubPre;
  logic        rxSubValid = 1'b0;
  logic        rxSubReady;
  logic        rxSubLeft = 1'b0;
  logic [23:0] rxSubAudio = '0;
  logic        rxSubP = 1'b0, rxSubC = 1'b0, rxSubU = 1'b0, rxSubV = 1'b0;
  logic [3:0]  rxSubPre = '0;
  logic        rxWordValid;
  logic        rxWordReady = 1'b0;
  logic [31:0] rxWord;

  sample_word_fmt u_sample_word_fmt (.*);

  always #2.5 clk = ~clk;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit finished = 0;
  logic [31:0] seed = 32'h1234_5678;

  // reference model state
  bit mLeft, mPhase, mHeld;
  int mHeldVal;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      finished = 1;
      bad++;
      total++;
      $display("FAIL watchdog expired act=%0d exp<=150000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic logic [31:0] rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return {seed[15:0], seed[31:16]} ^ (seed >> 7);
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  task automatic doReset(int mode, bit pack);
    @(negedge clk);
    rstN = 1'b0;
    cfgMode = mode[1:0];
    cfgPack = pack;
    txWordValid = 0; rxSubValid = 0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    mLeft = 1; mPhase = 0; mHeld = 0; mHeldVal = 0;
    #1;
    chk("R11", "tag after reset", {31'd0, txSubLeft}, 32'd1);
  endtask

  task automatic step(string txTag, string rxTag);
    int m;
    bit pk;
    logic [31:0] w, e, a, n;
    int ones;
    bit expWv, expSr, expTr;
    m  = int'(cfgMode);
    pk = cfgPack && (m == 0);
    // drive at negedge
    w = rnd();
    txWord      = rnd();
    txWordValid = w[0] | w[1];
    txSubReady  = w[2] | w[3];
    rxSubValid  = w[4] | w[5];
    rxSubLeft   = w[6];
    rxWordReady = w[7] | w[8];
    n = rnd();
    rxSubAudio = n[23:0];
    {rxSubP, rxSubC, rxSubU, rxSubV} = n[27:24];
    rxSubPre = n[31:28];
    #1;
    // ---- transmit expectations
    chk("R7", "txSubValid", {31'd0, txSubValid}, {31'd0, txWordValid});
    chk("R6", "txSubLeft", {31'd0, txSubLeft}, {31'd0, mLeft});
    expTr = pk ? (mPhase && txSubReady) : txSubReady;
    chk(pk ? "R4" : "R7", "txWordReady", {31'd0, txWordReady}, {31'd0, expTr});
    if (txWordValid) begin
      if (pk)             a = ((mPhase ? (txWord >> 16) : txWord) & 32'hffff) << 8;
      else if (m == 0)    a = (txWord & 32'hffff) << 8;
      else if (m == 1)    a = (txWord & 32'hfffff) << 4;
      else if (m == 2)    a = txWord & 32'hffffff;
      else                a = (txWord >> 4) & 32'hffffff;
      chk(txTag, "txSubAudio", {8'd0, txSubAudio}, a);
      if (m == 3) begin
        chk("R2", "txSubP", {31'd0, txSubP}, {31'd0, txWord[31]});
        chk("R2", "txSubCUV", {29'd0, txSubC, txSubU, txSubV}, {29'd0, txWord[30], txWord[29], txWord[28]});
        chk("R2", "txSubPre", {28'd0, txSubPre}, txWord & 32'hf);
      end else begin
        ones = $countones(a);
        chk("R3", "txSubP", {31'd0, txSubP}, ones % 2);
        chk("R1", "txSubCUV+pre", {25'd0, txSubC, txSubU, txSubV, txSubPre}, 32'd0);
      end
    end
    // ---- receive expectations
    if (pk) begin
      if (rxSubLeft || !mHeld) begin
        expSr = 1; expWv = 0;
      end else begin
        expSr = rxWordReady; expWv = rxSubValid;
      end
      e = (((rxSubAudio >> 8) & 32'hffff) << 16) | mHeldVal;
    end else begin
      expSr = rxWordReady; expWv = rxSubValid;
      e = ({28'd0, rxSubP, rxSubC, rxSubU, rxSubV} << 28);
      if (m == 3) e = e | ({8'd0, rxSubAudio} << 4) | rxSubPre;
      else begin
        e = e | ({28'd0, rxSubPre} << 24);
        if (m == 0)      e = e | (rxSubAudio >> 8);
        else if (m == 1) e = e | (rxSubAudio >> 4);
        else             e = e | rxSubAudio;
      end
    end
    chk(pk ? "R10" : "R7", "rxSubReady", {31'd0, rxSubReady}, {31'd0, expSr});
    chk(pk ? "R10" : "R7", "rxWordValid", {31'd0, rxWordValid}, {31'd0, expWv});
    if (expWv) chk(rxTag, "rxWord", rxWord, e);
    // ---- advance model with values seen at the coming edge
    if (txWordValid && txSubReady) begin
      mLeft = !mLeft;
      if (pk) mPhase = !mPhase;
    end
    if (pk && rxSubValid) begin
      if (rxSubLeft) begin
        mHeld = 1; mHeldVal = int'((rxSubAudio >> 8) & 24'hffff);
      end else if (expSr) mHeld = 0;
    end
    @(negedge clk);
  endtask

  task automatic runCfg(int mode, bit pack, string txTag, string rxTag);
    doReset(mode, pack);
    for (int i = 0; i < 80; i++) step(txTag, rxTag);
  endtask

  initial begin
    runCfg(0, 0, "R1", "R8");
    runCfg(1, 0, "R1", "R8");
    runCfg(2, 0, "R1", "R8");
    runCfg(3, 0, "R2", "R9");
    runCfg(0, 1, "R4", "R10");
    runCfg(1, 1, "R5", "R5");
    runCfg(2, 1, "R5", "R5");
    runCfg(3, 1, "R5", "R5");
    runCfg(0, 1, "R4", "R10");
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule